// File: doc/BRIEF.md
# ADC Control/Status Register Sequencer

This block holds the control and status byte of one analog-to-digital converter module and drives the conversion requests for it. Software reaches the byte through a byte-wide register port. The byte holds an interrupt enable, a two-bit conversion mode, a three-bit channel select and an end-of-conversion flag. A start input comes from a separate control register. While it is high, the block asks an abstract converter for conversions through a request/done handshake and names the channel on `conv_ch`.

In single mode the block converts the selected channel once. It sets the end flag and then waits in a hold state until start is lowered. In scan mode the group of four channels is picked by the top channel-select bit: channels 0–3 when it is 0, channels 4–7 when it is 1. The group is converted in ascending order and repeated while start stays high, and the end flag rises only when the last channel of each pass completes.

The sequencer has three states. IDLE goes to CONVERT when start is high. CONVERT stays in CONVERT to advance within a scan group, wraps back to the group base, goes to HOLD after a single-mode conversion, or returns to IDLE when start is low. HOLD returns to IDLE when start is low. The flag clears on a zero-write only if software has read it as one since it last changed, or on a DMA-style result read. The interrupt request is the flag gated by the enable.

Top module: `adc_csr_seq`

## Requirements
- R1: After reset the register reads 0x08, `irq` is low and `conv_req` is low.
- R2: The read value is {flag[7], enable[6], mode[5:4], 1'b1 at bit 3, channel[2:0]}. Bit 3 always reads 1 whatever is written.
- R3: In single mode (mode 00) exactly one conversion of the selected channel is requested per start assertion. The flag sets when its done pulse is taken, and no further request follows until start is lowered and raised again.
- R4: In scan mode (mode 01) channels {ch[2],00} to {ch[2],11} are requested in ascending order, repeating while start is high. The flag sets only when the fourth channel of a pass completes.
- R5: Writing 1 to bit 7 never sets the flag. The flag rises only on a conversion end.
- R6: A write with bit 7 = 0 clears the flag only if the flag was read as 1 since it last changed. Otherwise the flag stays set.
- R7: A pulse on `dma_rd_clr` clears the flag when `dma_dis_sel` is low and has no effect when it is high.
- R8: `irq` is high exactly when the flag and the enable bit are both 1.
- R9: While `start` is high, writes to the mode and channel fields are ignored. Writes to the enable bit still take effect.
- R10: Mode codes 10 and 11 behave as single mode.
- R11: Once `start` is sampled low and no request is pending, `conv_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_rd | input | 1 | Read strobe, qualified by reg_sel |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational view of the register) |
| start | input | 1 | Conversion start bit from the separate control register |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ch | output | 3 | Channel being converted |
| conv_done | input | 1 | One-cycle conversion completion from the converter |
| dma_rd_clr | input | 1 | DMA result-read pulse |
| dma_dis_sel | input | 1 | When high, the DMA read does not clear the flag |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
The sequencer is run in single mode on channel 5, in scan mode on the low group (channel-select 1) and on the high group (channel-select 4) across two passes, and with a prohibited mode code. The single run and the prohibited-code run tell a single conversion apart from repeating. The two scan groups show that only the top channel-select bit picks the group. The second scan pass shows the flag rising at the group end and not on every channel. The flag-clearing patterns tell apart a zero-write with and without a prior read of one, a DMA read with the disable select high and low, and a write of one. A mode/channel write during a running scan shows the fields are frozen while the enable stays writable.

// File: rtl/adc_csr_pkg.sv
package adc_csr_pkg;
    localparam int REG_W   = 8;
    localparam int CH_W    = 3;
    localparam int GRP_W   = 2;
    localparam int BIT_FLAG = 7;
    localparam int BIT_IE   = 6;
    localparam int BIT_RSV  = 3;
    localparam logic [1:0] MODE_SCAN = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_HOLD    = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_end_flag.sv
module adc_end_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic zero_wr,
    input  logic rd_evt,
    input  logic dma_clr,
    output logic flag
);
    logic armed;
    logic flag_nxt;
    logic armed_nxt;

    // Set wins over any clear arriving in the same cycle
    always_comb begin
        flag_nxt = flag;
        if (set_evt)
            flag_nxt = 1'b1;
        else if ((zero_wr && armed) || dma_clr)
            flag_nxt = 1'b0;

        armed_nxt = armed;
        if (flag_nxt != flag)
            armed_nxt = 1'b0;
        else if (rd_evt && flag)
            armed_nxt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            flag  <= flag_nxt;
            armed <= armed_nxt;
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_csr_pkg::*;
#(
    parameter int CHW = CH_W,
    parameter int GW  = GRP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           scan,
    input  logic [CHW-1:0] sel_ch,
    input  logic           conv_done,
    output logic           conv_req,
    output logic [CHW-1:0] conv_ch,
    output logic           end_evt
);
    localparam logic [GW-1:0] GRP_LAST = '1;

    seq_state_t     state, state_nxt;
    logic [CHW-1:0] cur_ch, ch_nxt;
    logic [CHW-1:0] grp_base;

    assign grp_base = {sel_ch[CHW-1:GW], {GW{1'b0}}};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
        end else begin
            state  <= state_nxt;
            cur_ch <= ch_nxt;
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        ch_nxt    = cur_ch;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_CONVERT;
                    ch_nxt    = scan ? grp_base : sel_ch;
                end
            end
            ST_CONVERT: begin
                if (conv_done) begin
                    if (!scan) begin
                        state_nxt = ST_HOLD;
                    end else begin
                        if (cur_ch[GW-1:0] == GRP_LAST)
                            ch_nxt = {cur_ch[CHW-1:GW], {GW{1'b0}}};
                        else
                            ch_nxt = cur_ch + 1'b1;
                        state_nxt = start ? ST_CONVERT : ST_IDLE;
                    end
                end else if (!start) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!start)
                    state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        conv_req = (state == ST_CONVERT);
        conv_ch  = cur_ch;
        end_evt  = 1'b0;
        if (state == ST_CONVERT && conv_done)
            end_evt = !scan || (cur_ch[GW-1:0] == GRP_LAST);
    end
endmodule

// File: rtl/adc_csr_seq.sv
module adc_csr_seq
    import adc_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             start,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_ch,
    input  logic             conv_done,
    input  logic             dma_rd_clr,
    input  logic             dma_dis_sel,
    output logic             irq
);
    logic            wr_en, rd_en;
    logic            ie;
    logic [1:0]      mode;
    logic [CH_W-1:0] ch_sel;
    logic            flag;
    logic            end_evt;

    assign wr_en = reg_sel && reg_wr;
    assign rd_en = reg_sel && reg_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie     <= 1'b0;
            mode   <= 2'b00;
            ch_sel <= '0;
        end else if (wr_en) begin
            ie <= reg_wdata[BIT_IE];
            if (!start) begin
                mode   <= reg_wdata[5:4];
                ch_sel <= reg_wdata[CH_W-1:0];
            end
        end
    end

    adc_end_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (end_evt),
        .zero_wr (wr_en && !reg_wdata[BIT_FLAG]),
        .rd_evt  (rd_en),
        .dma_clr (dma_rd_clr && !dma_dis_sel),
        .flag    (flag)
    );

    adc_seq_fsm #(.CHW(CH_W), .GW(GRP_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .scan      (mode == MODE_SCAN),
        .sel_ch    (ch_sel),
        .conv_done (conv_done),
        .conv_req  (conv_req),
        .conv_ch   (conv_ch),
        .end_evt   (end_evt)
    );

    assign reg_rdata = {flag, ie, mode, 1'b1, ch_sel};
    assign irq       = flag && ie;
endmodule

// File: rtl/adc_csr_seq_chk.sv
module adc_csr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       conv_done,
    input logic       conv_req,
    input logic [2:0] conv_ch,
    input logic [7:0] reg_rdata,
    input logic       irq
);
    AST_RSV_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3]); // R2

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_rdata[7] && reg_rdata[6])); // R8

    AST_FLAG_SETS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[7] && !conv_done) |=> !reg_rdata[7]); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && $past(start)) |-> ($stable(reg_rdata[5:4]) && $stable(reg_rdata[2:0]))); // R9

    AST_SCAN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && reg_rdata[5:4] == 2'b01) |-> (conv_ch[2] == reg_rdata[2])); // R4

    AST_SINGLE_CH: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && reg_rdata[5:4] != 2'b01) |-> (conv_ch == reg_rdata[2:0])); // R3

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !conv_req) |=> !conv_req); // R11
endmodule

bind adc_csr_seq adc_csr_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .conv_done (conv_done),
    .conv_req  (conv_req),
    .conv_ch   (conv_ch),
    .reg_rdata (reg_rdata),
    .irq       (irq)
);

// File: tb/adc_csr_seq_test.sv
`timescale 1ns/1ps
module adc_csr_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       start = 1'b0;
    logic       conv_req;
    logic [2:0] conv_ch;
    logic       conv_done = 1'b0;
    logic       dma_rd_clr = 1'b0, dma_dis_sel = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [2:0] exp_q[$];
    string cur_req = "R3";
    int cnt = 0;

    always #10 clk = ~clk;

    adc_csr_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .start(start), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_done(conv_done), .dma_rd_clr(dma_rd_clr),
        .dma_dis_sel(dma_dis_sel), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic reg_read(output logic [7:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic push(input logic [2:0] c);
        exp_q.push_back(c);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq;
        while (!irq) @(negedge clk);
    endtask

    // Converter model and scoreboard monitor
    always @(negedge clk) begin
        if (conv_done) begin
            conv_done = 1'b0;
            cnt = 0;
        end else if (conv_req) begin
            cnt++;
            if (cnt == 2) begin
                cnt = 0;
                conv_done = 1'b1;
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_req, " unexpected conversion"}, conv_ch, 0);
                end else begin
                    logic [2:0] e;
                    e = exp_q.pop_front();
                    check(conv_ch == e, {cur_req, " channel order"}, conv_ch, e);
                end
            end
        end else begin
            cnt = 0;
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        idle(3);
        // R1 reset state
        check(reg_rdata == 8'h08, "R1 reset value", reg_rdata, 8'h08);
        check(irq == 1'b0 && conv_req == 1'b0, "R1 irq/req idle", {irq, conv_req}, 0);
        rst_n = 1'b1;
        idle(2);

        // R2 reserved bit, R5 writing one does not set flag
        reg_write(8'hFF);
        check(reg_rdata == 8'h7F, "R2 R5 write all ones", reg_rdata, 8'h7F);

        // R3 single mode on channel 5
        cur_req = "R3";
        reg_write(8'h45);
        push(3'd5);
        start = 1'b1;
        wait_irq();
        idle(10);
        check(conv_req == 1'b0 && exp_q.size() == 0, "R3 single hold", conv_req, 0);
        start = 1'b0;
        idle(2);

        // R6 zero write without read leaves flag set
        reg_write(8'h45);
        check(irq == 1'b1, "R6 unarmed zero write", irq, 1);
        reg_read(rd);
        check(rd == 8'hCD, "R3 flag after single", rd, 8'hCD);
        reg_write(8'h45);
        check(irq == 1'b0, "R6 armed zero write clears", irq, 0);
        reg_read(rd);
        check(rd == 8'h4D, "R6 readback after clear", rd, 8'h4D);

        // R4 scan low group
        cur_req = "R4";
        reg_write(8'h51);
        for (int i = 0; i < 4; i++) push(i[2:0]);
        start = 1'b1;
        wait_irq();
        start = 1'b0;
        check(exp_q.size() == 0, "R4 flag at low group end", exp_q.size(), 0);
        idle(3);

        // R4 scan high group, two passes; R9 frozen fields
        reg_read(rd);
        check(rd == 8'hD9, "R4 flag after low scan", rd, 8'hD9);
        reg_write(8'h54);
        check(irq == 1'b0, "R6 clear before high scan", irq, 0);
        for (int p = 0; p < 2; p++)
            for (int i = 4; i < 8; i++) push(i[2:0]);
        start = 1'b1;
        wait_irq();
        check(exp_q.size() == 4, "R4 flag only after full group", exp_q.size(), 4);
        reg_write(8'h40);
        check(irq == 1'b1, "R9 R6 enable kept, flag kept", irq, 1);
        while (exp_q.size() != 0) @(negedge clk);
        start = 1'b0;
        idle(4);
        check(conv_req == 1'b0, "R11 stop after start low", conv_req, 0);
        reg_read(rd);
        check(rd == 8'hDC, "R9 mode/ch ignored while running", rd, 8'hDC);

        // R7 DMA clear
        @(negedge clk); dma_dis_sel = 1'b1; dma_rd_clr = 1'b1;
        @(negedge clk); dma_rd_clr = 1'b0;
        check(irq == 1'b1, "R7 dma read with disable high", irq, 1);
        @(negedge clk); dma_dis_sel = 1'b0; dma_rd_clr = 1'b1;
        @(negedge clk); dma_rd_clr = 1'b0;
        check(irq == 1'b0, "R7 dma read clears", irq, 0);

        // R10 prohibited mode acts as single
        cur_req = "R10";
        reg_write(8'h64);
        push(3'd4);
        start = 1'b1;
        wait_irq();
        idle(10);
        check(conv_req == 1'b0 && exp_q.size() == 0, "R10 prohibited as single", conv_req, 0);
        start = 1'b0;
        idle(2);
        reg_read(rd);
        check(rd == 8'hEC, "R10 readback", rd, 8'hEC);

        // R8 irq gated by enable; R5 write of one keeps flag
        reg_write(8'hA4);
        check(irq == 1'b0, "R8 irq off with enable low", irq, 0);
        reg_read(rd);
        check(rd == 8'hAC, "R8 R5 flag kept, enable off", rd, 8'hAC);

        idle(5);
        finish_run();
    end
endmodule